// File: doc/BRIEF.md
# Inter-processor interrupt register block

This block lets several processing agents signal each other through a small set of 32-bit registers on a simple bus. Eleven agents are served, and each owns one fixed bit position in every register word: bits 0, 8, 9, 16, 17, 18, 19, 24, 25, 26 and 27. Agent number k (counting from 0) is the k-th lowest of these positions, so agent 0 is bit 0, agent 1 is bit 8, and agent 10 is bit 27. All other bit positions are reserved.

A bus master sends a doorbell by writing the trigger word. Each valid bit written produces a one-cycle pulse on that agent's trigger output. Doorbells arriving from other agents set bits in a pending status word. Software clears these bits by writing 1 to them. A mask word gates the pending bits onto a single interrupt line. Software cannot write the mask directly. It changes the mask only by writing set-bit strobes to an unmask word or a mask word-strobe. Per-agent observation outputs show the pending bits. A 32-bit observation input can be read back through the bus.

The bus is a one-cycle request port: a write takes effect at the clock edge that samples it. A read returns its data with a response strobe one cycle later.

Top module: `ipi_regblock`

## Requirements
- R1: After reset, trig_pulse, obs_out and irq are all 0, the status word (offset 0x10) reads 0, the trigger word (0x00) reads 0, and the mask word (0x14) reads 0x0F0F0301, so every agent starts masked.
- R2: A write to offset 0x00 raises trig_pulse[k] for exactly the one cycle after the write edge, for each agent k whose bit is 1 in the written data. Agent k is the k-th lowest valid position. The trigger word always reads 0.
- R3: A 1 on src_in at a valid position at a clock edge sets that status bit. The bit stays set until a write to 0x10 carries a 1 in that position.
- R4: If a source line and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set. A clear aimed at a different bit in that cycle still takes effect.
- R5: Writes to offset 0x14 are ignored. Writing 1s to offset 0x18 clears the matching mask bits. Writing 1s to offset 0x1C sets them. Both 0x18 and 0x1C read 0.
- R6: irq is a register. It is 1 exactly one cycle after the status word holds a set bit whose mask bit is 0. It is not yet 1 in the cycle the status bit first appears.
- R7: A read of offset 0x04 returns the obs_in value sampled at the read edge, with the reserved positions forced to 0.
- R8: obs_out[k] equals the current status bit of agent k.
- R9: Reserved positions (mask 0xF0F0FCFE) read 0 in every register, and writing 1s to them changes nothing.
- R10: A read of an unmapped or non-word-aligned offset returns 0. A write to one changes no register and no output.
- R11: rsp_valid is 1 exactly in the cycle after a read request, with rsp_rdata valid in that cycle. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (cycle after read request) |
| rsp_rdata | output | 32 | Read data |
| src_in | input | 32 | Incoming doorbell lines, one per valid bit position |
| obs_in | input | 32 | Observation lines readable at offset 0x04 |
| trig_pulse | output | NUM_AGENTS | One-cycle doorbell pulses, one per agent |
| obs_out | output | NUM_AGENTS | Pending status per agent |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
Several assertions compare each clocked signal with its value in the previous cycle. These assertions assume that reset is applied from time zero and that req_valid, req_write and src_in hold defined values at every edge after reset. The bench drives every input to 0 before reset is released. It changes inputs only on falling edges, and it lowers src_in to 0 between doorbell pulses. This way each status change comes from exactly one known source or clear write.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int DW = 32;

    // register byte offsets
    localparam logic [7:0] OFS_TRIG = 8'h00;
    localparam logic [7:0] OFS_OBS  = 8'h04;
    localparam logic [7:0] OFS_STAT = 8'h10;
    localparam logic [7:0] OFS_MASK = 8'h14;
    localparam logic [7:0] OFS_ENA  = 8'h18;
    localparam logic [7:0] OFS_DIS  = 8'h1C;

    typedef struct packed {
        logic trig;
        logic obs;
        logic stat;
        logic mask;
        logic ena;
        logic dis;
    } reg_sel_t;

    typedef struct packed {
        logic [DW-1:0] trig;
        logic [DW-1:0] stat;
        logic [DW-1:0] mask;
        logic          irq;
        logic [DW-1:0] rdata;
        logic          rvalid;
    } ipi_state_t;

    function automatic int count_set(logic [DW-1:0] m);
        int c;
        c = 0;
        for (int b = 0; b < DW; b++) begin
            if (m[b]) c++;
        end
        return c;
    endfunction

    function automatic int nth_set_bit(logic [DW-1:0] m, int n);
        int c;
        int r;
        c = 0;
        r = 0;
        for (int b = 0; b < DW; b++) begin
            if (m[b]) begin
                if (c == n) r = b;
                c++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ipi_decode.sv
module ipi_decode #(
    parameter int ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output ipi_pkg::reg_sel_t wr_sel,
    output ipi_pkg::reg_sel_t rd_sel,
    output logic              rd_req
);
    import ipi_pkg::*;

    reg_sel_t hit;

    always_comb begin
        hit.trig = (req_addr == ADDR_W'(OFS_TRIG));
        hit.obs  = (req_addr == ADDR_W'(OFS_OBS));
        hit.stat = (req_addr == ADDR_W'(OFS_STAT));
        hit.mask = (req_addr == ADDR_W'(OFS_MASK));
        hit.ena  = (req_addr == ADDR_W'(OFS_ENA));
        hit.dis  = (req_addr == ADDR_W'(OFS_DIS));
        wr_sel   = (req_valid && req_write)  ? hit : '0;
        rd_sel   = (req_valid && !req_write) ? hit : '0;
        rd_req   = req_valid && !req_write;
    end

endmodule

// File: rtl/ipi_bit_map.sv
module ipi_bit_map #(
    parameter logic [31:0] WORD_MASK  = 32'h0F0F_0301,
    parameter int          NUM_AGENTS = 11
) (
    input  logic [31:0]           word,
    output logic [NUM_AGENTS-1:0] agents
);
    for (genvar k = 0; k < NUM_AGENTS; k++) begin : g_agent
        localparam int POS = ipi_pkg::nth_set_bit(WORD_MASK, k);
        assign agents[k] = word[POS];
    end

endmodule

// File: rtl/ipi_regblock.sv
module ipi_regblock #(
    parameter int          ADDR_W     = 8,
    parameter logic [31:0] VALID_MASK = 32'h0F0F_0301,
    parameter logic [31:0] MASK_RST   = 32'h0F0F_0301,
    localparam int         NUM_AGENTS = ipi_pkg::count_set(VALID_MASK)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [31:0]           req_wdata,
    output logic                  rsp_valid,
    output logic [31:0]           rsp_rdata,
    input  logic [31:0]           src_in,
    input  logic [31:0]           obs_in,
    output logic [NUM_AGENTS-1:0] trig_pulse,
    output logic [NUM_AGENTS-1:0] obs_out,
    output logic                  irq
);
    import ipi_pkg::*;

    localparam ipi_state_t RESET_STATE = '{
        trig:   '0,
        stat:   '0,
        mask:   MASK_RST & VALID_MASK,
        irq:    1'b0,
        rdata:  '0,
        rvalid: 1'b0
    };

    reg_sel_t   wr_sel;
    reg_sel_t   rd_sel;
    logic       rd_req;
    ipi_state_t st_d;
    ipi_state_t st_q;
    logic [31:0] wmask;
    logic [31:0] clr_bits;
    logic [31:0] rd_mux;

    ipi_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .wr_sel    (wr_sel),
        .rd_sel    (rd_sel),
        .rd_req    (rd_req)
    );

    always_comb begin
        st_d     = st_q;
        wmask    = req_wdata & VALID_MASK;

        // trigger: live for one cycle only
        st_d.trig = wr_sel.trig ? wmask : '0;

        // status: source set wins over write-1-to-clear
        clr_bits  = wr_sel.stat ? wmask : '0;
        st_d.stat = (st_q.stat & ~clr_bits) | (src_in & VALID_MASK);

        // mask: only through strobe words
        if (wr_sel.ena) begin
            st_d.mask = st_q.mask & ~wmask;
        end
        if (wr_sel.dis) begin
            st_d.mask = st_q.mask | wmask;
        end

        st_d.irq = |(st_q.stat & ~st_q.mask);

        rd_mux = '0;
        if (rd_sel.obs) begin
            rd_mux = obs_in & VALID_MASK;
        end
        if (rd_sel.stat) begin
            rd_mux = st_q.stat;
        end
        if (rd_sel.mask) begin
            rd_mux = st_q.mask;
        end
        st_d.rvalid = rd_req;
        st_d.rdata  = rd_req ? rd_mux : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    ipi_bit_map #(.WORD_MASK(VALID_MASK), .NUM_AGENTS(NUM_AGENTS)) u_trig_map (
        .word   (st_q.trig),
        .agents (trig_pulse)
    );

    ipi_bit_map #(.WORD_MASK(VALID_MASK), .NUM_AGENTS(NUM_AGENTS)) u_obs_map (
        .word   (st_q.stat),
        .agents (obs_out)
    );

    assign irq       = st_q.irq;
    assign rsp_valid = st_q.rvalid;
    assign rsp_rdata = st_q.rdata;

endmodule

// File: rtl/ipi_regblock_chk.sv
module ipi_regblock_chk #(
    parameter int          ADDR_W     = 8,
    parameter logic [31:0] VALID_MASK = 32'h0F0F_0301,
    parameter int          NUM_AGENTS = 11
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_write,
    input logic [ADDR_W-1:0]     req_addr,
    input logic [31:0]           src_in,
    input logic [NUM_AGENTS-1:0] trig_pulse,
    input logic [NUM_AGENTS-1:0] obs_out,
    input logic                  irq,
    input logic                  rsp_valid,
    input logic [31:0]           stat_q,
    input logic [31:0]           mask_q
);
    import ipi_pkg::*;

    logic wr_trig;
    logic wr_stat;
    logic wr_strobe;
    logic [31:0] src_v;

    assign wr_trig   = req_valid && req_write && (req_addr == ADDR_W'(OFS_TRIG));
    assign wr_stat   = req_valid && req_write && (req_addr == ADDR_W'(OFS_STAT));
    assign wr_strobe = req_valid && req_write &&
                       ((req_addr == ADDR_W'(OFS_ENA)) || (req_addr == ADDR_W'(OFS_DIS)));
    assign src_v     = src_in & VALID_MASK;

    // R2: a trigger pulse only follows a trigger write
    a_r2_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig_pulse) |-> $past(wr_trig));

    // R3: a pending bit only falls after a clear write
    a_r3_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R4: every raised source bit is pending next cycle, even under a clear
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_v) |=> ((stat_q & $past(src_v)) == $past(src_v)));

    // R5: the mask moves only on strobe writes
    a_r5_mask_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe |=> $stable(mask_q));

    // R6: interrupt follows unmasked pending state by one cycle
    a_r6_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(stat_q & ~mask_q))));

    // R8: observation outputs carry as many bits as the status word
    a_r8_obs_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(obs_out) == $countones(stat_q));

    // R9: reserved positions never hold state
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q | mask_q) & ~VALID_MASK) == '0);

    // R11: response strobe one cycle after a read request
    a_r11_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_valid == $past(req_valid && !req_write)));

endmodule

bind ipi_regblock ipi_regblock_chk #(
    .ADDR_W     (ADDR_W),
    .VALID_MASK (VALID_MASK),
    .NUM_AGENTS (NUM_AGENTS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .src_in     (src_in),
    .trig_pulse (trig_pulse),
    .obs_out    (obs_out),
    .irq        (irq),
    .rsp_valid  (rsp_valid),
    .stat_q     (st_q.stat),
    .mask_q     (st_q.mask)
);

// File: tb/ipi_regblock_test.sv
module ipi_regblock_test;

    localparam int NA = 11;
    localparam logic [31:0] VM = 32'h0F0F_0301;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [31:0] src_in = '0;
    logic [31:0] obs_in = '0;
    logic [NA-1:0] trig_pulse;
    logic [NA-1:0] obs_out;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    int pos [NA] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};

    always #2.5 clk = ~clk;

    ipi_regblock uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .src_in(src_in), .obs_in(obs_in),
        .trig_pulse(trig_pulse), .obs_out(obs_out), .irq(irq)
    );

    function automatic logic [NA-1:0] agents_of(logic [31:0] w);
        logic [NA-1:0] v;
        v = '0;
        for (int k = 0; k < NA; k++) v[k] = w[pos[k]];
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        n_checks++;
        if (rsp_valid !== 1'b1) begin
            n_errors++;
            $display("FAIL R11: rsp_valid actual %b expected 1", rsp_valid);
        end
        d = rsp_rdata;
    endtask

    task automatic src_pulse(logic [31:0] s);
        @(negedge clk);
        src_in = s;
        @(negedge clk);
        src_in = '0;
    endtask

    initial begin : watchdog
        #500000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        logic [31:0] exp_mask;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 trig_pulse", 32'(trig_pulse), 0);
        chk("R1 obs_out", 32'(obs_out), 0);
        chk("R1 irq", 32'(irq), 0);
        bus_read(8'h14, rd); chk("R1 mask reset", rd, 32'h0F0F_0301);
        bus_read(8'h10, rd); chk("R1 status reset", rd, 0);
        bus_read(8'h00, rd); chk("R1 trigger reads zero", rd, 0);
        @(negedge clk);
        chk("R11 rsp_valid idle", 32'(rsp_valid), 0);

        // R2 / R9 trigger sweep over every bit position
        for (int b = 0; b < 32; b++) begin
            bus_write(8'h00, 32'h1 << b);
            chk("R2 pulse", 32'(trig_pulse), 32'(agents_of((32'h1 << b) & VM)));
            @(negedge clk);
            chk("R2 pulse one cycle", 32'(trig_pulse), 0);
        end
        bus_write(8'h00, 32'hFFFF_FFFF);
        chk("R2 all agents pulse", 32'(trig_pulse), 32'h7FF);
        bus_read(8'h00, rd); chk("R2 trigger reads zero after write", rd, 0);
        chk("R2 pulse ended", 32'(trig_pulse), 0);

        // R7 observation readback sweep
        for (int b = 0; b < 32; b++) begin
            obs_in = 32'h1 << b;
            bus_read(8'h04, rd);
            chk("R7 obs read", rd, (32'h1 << b) & VM);
        end
        obs_in = 32'hFFFF_FFFF;
        bus_read(8'h04, rd); chk("R7 obs all ones", rd, VM);
        obs_in = '0;

        // R5 mask strobes
        bus_write(8'h14, 32'h0);
        bus_read(8'h14, rd); chk("R5 mask write ignored", rd, 32'h0F0F_0301);
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_read(8'h14, rd); chk("R5 enable clears mask", rd, 0);
        bus_write(8'h1C, 32'h0000_0100);
        bus_read(8'h14, rd); chk("R5 disable sets bit", rd, 32'h100);
        bus_read(8'h18, rd); chk("R5 enable reads zero", rd, 0);
        bus_read(8'h1C, rd); chk("R5 disable reads zero", rd, 0);
        bus_write(8'h1C, 32'hFFFF_FFFF);
        bus_read(8'h14, rd); chk("R9 mask reserved stay zero", rd, VM);
        exp_mask = VM;

        // R3 / R8 / R6 status sweep, all masked
        for (int b = 0; b < 32; b++) begin
            src_pulse(32'h1 << b);
            chk("R8 obs_out follows status", 32'(obs_out), 32'(agents_of((32'h1 << b) & VM)));
            @(negedge clk); @(negedge clk);
            bus_read(8'h10, rd);
            chk("R3 status held", rd, (32'h1 << b) & VM);
            chk("R6 masked no irq", 32'(irq), 0);
            bus_write(8'h10, 32'hFFFF_FFFF);
            chk("R3 cleared by write one", 32'(obs_out), 0);
        end

        // R6 interrupt per agent
        for (int k = 0; k < NA; k++) begin
            int j;
            j = (k + 1) % NA;
            bus_write(8'h18, 32'h1 << pos[k]);
            src_pulse(32'h1 << pos[j]);
            @(negedge clk);
            chk("R6 other agent masked", 32'(irq), 0);
            src_pulse(32'h1 << pos[k]);
            chk("R6 irq not same cycle", 32'(irq), 0);
            @(negedge clk);
            chk("R6 irq after one cycle", 32'(irq), 1);
            bus_write(8'h10, 32'h1 << pos[k]);
            @(negedge clk);
            chk("R6 irq drops after clear", 32'(irq), 0);
            bus_write(8'h10, 32'h1 << pos[j]);
            bus_write(8'h1C, 32'h1 << pos[k]);
        end
        bus_read(8'h14, rd); chk("R5 mask restored", rd, exp_mask);

        // R4 set wins over clear
        src_pulse(32'h0000_0300);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h10; req_wdata = 32'h0000_0300;
        src_in = 32'h0000_0100;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; src_in = '0;
        bus_read(8'h10, rd); chk("R4 set beats clear", rd, 32'h0000_0100);
        bus_write(8'h10, 32'hFFFF_FFFF);

        // R10 unmapped / misaligned
        src_pulse(32'h0100_0000);
        bus_write(8'h08, 32'hFFFF_FFFF);
        chk("R10 write unmapped no pulse", 32'(trig_pulse), 0);
        bus_write(8'h11, 32'hFFFF_FFFF);
        bus_write(8'h15, 32'hFFFF_FFFF);
        bus_write(8'h19, 32'hFFFF_FFFF);
        bus_write(8'h01, 32'hFFFF_FFFF);
        chk("R10 misaligned no pulse", 32'(trig_pulse), 0);
        bus_read(8'h10, rd); chk("R10 status unchanged", rd, 32'h0100_0000);
        bus_read(8'h14, rd); chk("R10 mask unchanged", rd, VM);
        bus_read(8'h08, rd); chk("R10 unmapped read", rd, 0);
        bus_read(8'h20, rd); chk("R10 past map read", rd, 0);
        bus_read(8'h11, rd); chk("R10 misaligned read", rd, 0);
        bus_write(8'h10, 32'hF0F0_FCFE);
        bus_read(8'h10, rd); chk("R9 reserved clear ignored", rd, 32'h0100_0000);
        bus_write(8'h10, 32'h0100_0000);
        bus_read(8'h10, rd); chk("R3 final clear", rd, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule